// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Detection

This block is a small memory-mapped general-purpose pin controller. Each of its pins (twelve by default, sixteen at most) has an output latch and a direction bit that together drive the pin, plus an input readback taken through a two-flop synchronizer. Software reaches every register over a plain 32-bit word bus. Writes take effect on the clock edge. Reads are combinational from the byte address.

Each pin also has its own trigger detector. The detector is programmed with a 3-bit mode: rising edge, falling edge, any edge, level high or level low. A pin that is enabled and meets its condition sets a latched pending bit. Software acknowledges that bit by writing a one to the acknowledge register. A separate mask, changed only through a set-port and a clear-port, keeps a pending bit off the single interrupt output without stopping it from latching. A stored selection word is passed out for a neighbouring pin multiplexer. A soft-reset word returns the whole block to its reset state while it holds a one.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After rst_n is released, every register reads zero, pin_o, pin_oe_o and use_sel_o are zero and irq_o is low.
- R2: pin_o follows the output word (byte 0x18) and pin_oe_o follows the direction word (byte 0x20, 1 = drive). In every register except the two mode words, bits at or above PINS read as zero whatever was written.
- R3: The input word (byte 0x1C) shows a change on pin_i on the second rising clock edge after the change and not before.
- R4: Mode 1 (rising) sets a pin's pending bit (status word, byte 0x04) on a low-to-high transition of the synchronized input only.
- R5: Mode 0 (falling) sets the pending bit on a high-to-low transition only.
- R6: Mode 4 (any edge) sets the pending bit on both transitions.
- R7: Mode 3 (level high) and mode 2 (level low) set the pending bit whenever the level is present, so an acknowledge has no lasting effect while the level holds.
- R8: A pin whose bit in the enable word (byte 0x00) is zero never sets its pending bit.
- R9: Writing ones to byte 0x10 masks those pins and writing ones to byte 0x14 unmasks them. Zero bits leave the mask alone, and the mask reads back at 0x10. The display word (byte 0x08) equals pending AND NOT mask, and irq_o is high exactly when that word is nonzero. Masking does not stop latching.
- R10: Writing ones to the acknowledge word (byte 0x0C) clears those pending bits when the condition is no longer present.
- R11: The 3-bit mode of pin k sits at bits 4k+2..4k of byte 0x24 for k < 8, and at bits 4(k-8)+2..4(k-8) of byte 0x28 for k >= 8. The fourth bit of each nibble, and the nibbles of unimplemented pins, read zero. Codes 5 to 7 detect nothing.
- R12: Writing 1 and then 0 to bit 0 of byte 0x3C leaves enable, mask, output, direction, modes, selection and pending bits at zero, and irq_o low.
- R13: The selection word (byte 0x38) stores PINS bits, reads back, and drives use_sel_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register word |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_i | input | PINS | Raw pin levels |
| pin_o | output | PINS | Output latch values |
| pin_oe_o | output | PINS | Drive enable per pin |
| use_sel_o | output | PINS | Stored pin selection word |
| irq_o | output | 1 | Combined unmasked interrupt request |

## Verification
A detector stuck in the wrong mode, or one that samples the wrong synchronizer stage, shows up at the status and display words, and at irq_o, three rising edges after the pin change, or never. The input-word check pins the synchronizer depth to exactly two edges. A pending bit that clears too eagerly or too weakly under a level mode is visible on the read that follows the acknowledge write. A mask updated through the wrong port, or a wrong nibble placement, shows on the very next read of the same word.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int BUS_W       = 32;
   localparam int ADDR_W      = 6;
   localparam int MODE_W      = 3;
   localparam int MODE_PITCH  = 4;
   localparam int PINS_PER_MW = 8;
   localparam int MAX_PINS    = 2 * PINS_PER_MW;

   // Word index (byte address / 4) of each register.
   typedef enum logic [3:0] {
      WD_ENABLE  = 4'd0,
      WD_PEND    = 4'd1,
      WD_SHOW    = 4'd2,
      WD_ACK     = 4'd3,
      WD_MSET    = 4'd4,
      WD_MCLR    = 4'd5,
      WD_OUT     = 4'd6,
      WD_IN      = 4'd7,
      WD_DIR     = 4'd8,
      WD_MODE_LO = 4'd9,
      WD_MODE_HI = 4'd10,
      WD_SEL     = 4'd14,
      WD_SOFTRST = 4'd15
   } reg_word_e;

   typedef enum logic [MODE_W-1:0] {
      TRIG_FALL = 3'd0,
      TRIG_RISE = 3'd1,
      TRIG_LOW  = 3'd2,
      TRIG_HIGH = 3'd3,
      TRIG_ANY  = 3'd4
   } trig_mode_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
   parameter int PINS   = 12,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] raw_i,
   output logic [PINS-1:0] cur_o,
   output logic [PINS-1:0] prev_o
);

   initial begin
      assert (STAGES >= 2) else $error("gpio_in_sync: STAGES must be at least 2");
   end

   logic [PINS-1:0] stage_q [STAGES];
   logic [PINS-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         prev_q <= '0;
      end else begin
         stage_q[0] <= raw_i;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         prev_q <= stage_q[STAGES-1];
      end
   end

   assign cur_o  = stage_q[STAGES-1];
   assign prev_o = prev_q;

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
   import gpio_irq_pkg::*;
#(
   parameter int PINS = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          soft_clr_i,
   input  logic [PINS-1:0]               lvl_i,
   input  logic [PINS-1:0]               lvl_prev_i,
   input  logic [PINS-1:0][MODE_W-1:0]   mode_i,
   input  logic [PINS-1:0]               en_i,
   input  logic [PINS-1:0]               ack_i,
   output logic [PINS-1:0]               pend_o
);

   logic [PINS-1:0] hit;
   logic [PINS-1:0] pend_q;

   for (genvar k = 0; k < PINS; k++) begin : g_pin
      logic rise, fall;
      assign rise = lvl_i[k] & ~lvl_prev_i[k];
      assign fall = ~lvl_i[k] & lvl_prev_i[k];

      always_comb begin
         case (mode_i[k])
            TRIG_FALL: hit[k] = fall;
            TRIG_RISE: hit[k] = rise;
            TRIG_LOW:  hit[k] = ~lvl_i[k];
            TRIG_HIGH: hit[k] = lvl_i[k];
            TRIG_ANY:  hit[k] = rise | fall;
            default:   hit[k] = 1'b0;
         endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pend_q[k] <= 1'b0;
         else if (soft_clr_i) pend_q[k] <= 1'b0;
         else                 pend_q[k] <= (pend_q[k] & ~ack_i[k]) | (en_i[k] & hit[k]);
      end

      AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pend_q[k]) |-> $past(en_i[k]))
         else $error("pending bit rose on a disabled pin"); // R8

      AST_LEVEL_HIGH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (!soft_clr_i && en_i[k] && mode_i[k] == TRIG_HIGH && lvl_i[k]) |=> pend_q[k])
         else $error("level-high condition did not hold the pending bit"); // R7

      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_i[k] && !en_i[k]) |=> !pend_q[k])
         else $error("acknowledge did not clear an idle pending bit"); // R10
   end

   assign pend_o = pend_q;

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
   import gpio_irq_pkg::*;
#(
   parameter int PINS = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic                          bus_we,
   input  logic [BUS_W-1:0]              bus_wdata,
   output logic [BUS_W-1:0]              bus_rdata,
   input  logic [PINS-1:0]               pend_i,
   input  logic [PINS-1:0]               lvl_i,
   output logic [PINS-1:0]               en_o,
   output logic [PINS-1:0]               mask_o,
   output logic [PINS-1:0]               out_o,
   output logic [PINS-1:0]               dir_o,
   output logic [PINS-1:0]               sel_o,
   output logic [PINS-1:0][MODE_W-1:0]   mode_o,
   output logic [PINS-1:0]               ack_o,
   output logic                          soft_rst_o
);

   localparam int LO_PINS = (PINS < PINS_PER_MW) ? PINS : PINS_PER_MW;

   logic [3:0]      word;
   logic [PINS-1:0] wbits;
   logic            soft_q;
   logic [PINS-1:0] en_q, mask_q, out_q, dir_q, sel_q;
   logic [PINS-1:0][MODE_W-1:0] mode_q;

   assign word  = bus_addr[ADDR_W-1:2];
   assign wbits = bus_wdata[PINS-1:0];

   logic unused_bits;
   assign unused_bits = ^{bus_addr[1:0], bus_wdata};

   function automatic logic hit_word(input logic [3:0] w, input reg_word_e target);
      return w == target;
   endfunction

   // soft reset word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 soft_q <= 1'b0;
      else if (bus_we && hit_word(word, WD_SOFTRST)) soft_q <= bus_wdata[0];
   end

   // plain read/write words and the set/clear mask
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         mask_q <= '0;
         out_q  <= '0;
         dir_q  <= '0;
         sel_q  <= '0;
      end else if (soft_q) begin
         en_q   <= '0;
         mask_q <= '0;
         out_q  <= '0;
         dir_q  <= '0;
         sel_q  <= '0;
      end else if (bus_we) begin
         if (hit_word(word, WD_ENABLE)) en_q   <= wbits;
         if (hit_word(word, WD_MSET))   mask_q <= mask_q | wbits;
         if (hit_word(word, WD_MCLR))   mask_q <= mask_q & ~wbits;
         if (hit_word(word, WD_OUT))    out_q  <= wbits;
         if (hit_word(word, WD_DIR))    dir_q  <= wbits;
         if (hit_word(word, WD_SEL))    sel_q  <= wbits;
      end
   end

   // per-pin mode fields on a four-bit pitch across two words
   for (genvar k = 0; k < PINS; k++) begin : g_mode
      localparam reg_word_e MWORD = (k < PINS_PER_MW) ? WD_MODE_LO : WD_MODE_HI;
      localparam int        MPOS  = (k % PINS_PER_MW) * MODE_PITCH;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             mode_q[k] <= '0;
         else if (soft_q)                        mode_q[k] <= '0;
         else if (bus_we && hit_word(word, MWORD)) mode_q[k] <= bus_wdata[MPOS +: MODE_W];
      end
   end

   assign ack_o = (bus_we && hit_word(word, WD_ACK)) ? wbits : '0;

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (word)
         WD_ENABLE:  bus_rdata[PINS-1:0] = en_q;
         WD_PEND:    bus_rdata[PINS-1:0] = pend_i;
         WD_SHOW:    bus_rdata[PINS-1:0] = pend_i & ~mask_q;
         WD_MSET:    bus_rdata[PINS-1:0] = mask_q;
         WD_OUT:     bus_rdata[PINS-1:0] = out_q;
         WD_IN:      bus_rdata[PINS-1:0] = lvl_i;
         WD_DIR:     bus_rdata[PINS-1:0] = dir_q;
         WD_SEL:     bus_rdata[PINS-1:0] = sel_q;
         WD_SOFTRST: bus_rdata[0]        = soft_q;
         WD_MODE_LO: begin
            for (int k = 0; k < LO_PINS; k++)
               bus_rdata[k*MODE_PITCH +: MODE_W] = mode_q[k];
         end
         WD_MODE_HI: begin
            for (int k = PINS_PER_MW; k < PINS; k++)
               bus_rdata[(k-PINS_PER_MW)*MODE_PITCH +: MODE_W] = mode_q[k];
         end
         default:    bus_rdata = '0;
      endcase
   end

   assign en_o       = en_q;
   assign mask_o     = mask_q;
   assign out_o      = out_q;
   assign dir_o      = dir_q;
   assign sel_o      = sel_q;
   assign mode_o     = mode_q;
   assign soft_rst_o = soft_q;

   AST_MASK_SET_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && word == WD_MSET && bus_wdata[0] && !soft_q) |=> mask_q[0])
      else $error("mask set-port write did not mask pin 0"); // R9

   AST_MASK_CLR_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && word == WD_MCLR && bus_wdata[0]) |=> !mask_q[0])
      else $error("mask clear-port write did not unmask pin 0"); // R9

   AST_SOFT_CLEARS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      soft_q |=> (en_q == '0 && dir_q == '0 && mask_q == '0 && out_q == '0 && sel_q == '0))
      else $error("soft reset left configuration set"); // R12

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int PINS        = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [5:0]        bus_addr,
   input  logic              bus_we,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [PINS-1:0]   pin_i,
   output logic [PINS-1:0]   pin_o,
   output logic [PINS-1:0]   pin_oe_o,
   output logic [PINS-1:0]   use_sel_o,
   output logic              irq_o
);

   if (PINS < 1 || PINS > MAX_PINS) begin : g_bad_pins
      $error("gpio_irq_ctrl: PINS must lie between 1 and 16");
   end

   logic [PINS-1:0] lvl, lvl_prev, en, mask, ack, pend;
   logic [PINS-1:0][MODE_W-1:0] mode;
   logic soft_rst;

   gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (pin_i),
      .cur_o  (lvl),
      .prev_o (lvl_prev)
   );

   gpio_cfg_regs #(.PINS(PINS)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_we     (bus_we),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .pend_i     (pend),
      .lvl_i      (lvl),
      .en_o       (en),
      .mask_o     (mask),
      .out_o      (pin_o),
      .dir_o      (pin_oe_o),
      .sel_o      (use_sel_o),
      .mode_o     (mode),
      .ack_o      (ack),
      .soft_rst_o (soft_rst)
   );

   gpio_trig_detect #(.PINS(PINS)) u_detect (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_clr_i (soft_rst),
      .lvl_i      (lvl),
      .lvl_prev_i (lvl_prev),
      .mode_i     (mode),
      .en_i       (en),
      .ack_i      (ack),
      .pend_o     (pend)
   );

   assign irq_o = |(pend & ~mask);

   AST_IRQ_QUIET_AFTER_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(soft_rst) |-> !irq_o)
      else $error("interrupt raised right after soft reset"); // R12

   AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr[5:2] != WD_MODE_LO && bus_addr[5:2] != WD_MODE_HI)
         |-> (bus_rdata >> PINS) == '0)
      else $error("read data above the pin count is not zero"); // R2

endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;

   localparam int PINS = 12;
   localparam logic [31:0] ALL = 32'h0000_0FFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [PINS-1:0] pin_i = '0;
   logic [PINS-1:0] pin_o, pin_oe_o, use_sel_o;
   logic irq_o;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_irq_ctrl #(.PINS(PINS)) i_gpio_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
      .pin_o(pin_o), .pin_oe_o(pin_oe_o), .use_sel_o(use_sel_o), .irq_o(irq_o)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic quiesce();
      wr(6'h00, 0); wr(6'h24, 0); wr(6'h28, 0); wr(6'h0C, ALL);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(6'h00, d); check("R1", "enable", d, 0);
      rd(6'h04, d); check("R1", "pending", d, 0);
      rd(6'h20, d); check("R1", "direction", d, 0);
      rd(6'h24, d); check("R1", "mode lo", d, 0);
      check("R1", "pins", {pin_o, pin_oe_o, use_sel_o, 3'b000, irq_o}, 0);
   endtask

   task automatic t_port();
      logic [31:0] d;
      wr(6'h20, 32'hFFFF_F0F0); wr(6'h18, 32'h0000_0A5A);
      #1;
      check("R2", "pin_oe_o", {20'h0, pin_oe_o}, 32'h0F0);
      check("R2", "pin_o", {20'h0, pin_o}, 32'hA5A);
      wr(6'h18, 32'hFFFF_FFFF);
      rd(6'h18, d); check("R2", "output high bits", d, ALL);
      rd(6'h20, d); check("R2", "direction high bits", d, 32'h0F0);
      wr(6'h00, 32'hFFFF_FFFF);
      rd(6'h00, d); check("R2", "enable high bits", d, ALL);
      wr(6'h00, 0); wr(6'h18, 0); wr(6'h20, 0);
   endtask

   task automatic t_input();
      logic [31:0] d;
      @(negedge clk); pin_i = 12'h3C5;
      @(posedge clk); #1 d = bus_rdata;
      bus_addr = 6'h1C; #1 d = bus_rdata;
      check("R3", "input after one edge", d, 0);
      @(posedge clk); #1 d = bus_rdata;
      check("R3", "input after two edges", d, 32'h3C5);
      @(negedge clk); pin_i = '0;
      settle();
      wr(6'h0C, ALL);
   endtask

   task automatic t_rise_fall();
      logic [31:0] d;
      wr(6'h24, 32'h0000_0001);          // pin0 rising, pin1 falling
      wr(6'h00, 32'h0000_0003);
      @(negedge clk); pin_i[0] = 1'b1; pin_i[1] = 1'b1;
      settle();
      rd(6'h04, d); check("R4", "rise sets pin0 only", d, 32'h001);
      check("R9", "irq with pending", {31'h0, irq_o}, 1);
      wr(6'h0C, 32'h1);
      @(negedge clk); pin_i[0] = 1'b0; pin_i[1] = 1'b0;
      settle();
      rd(6'h04, d); check("R5", "fall sets pin1 only", d, 32'h002);
      wr(6'h0C, 32'h3);
      rd(6'h04, d); check("R10", "ack clears edges", d, 0);
      check("R9", "irq idle", {31'h0, irq_o}, 0);
      quiesce();
   endtask

   task automatic t_any_edge();
      logic [31:0] d;
      wr(6'h28, 32'h0000_0040);          // pin9 any edge
      wr(6'h00, 32'h0000_0200);
      @(negedge clk); pin_i[9] = 1'b1; settle();
      rd(6'h04, d); check("R6", "any edge rise", d, 32'h200);
      wr(6'h0C, 32'h200);
      rd(6'h04, d); check("R10", "ack any edge", d, 0);
      @(negedge clk); pin_i[9] = 1'b0; settle();
      rd(6'h04, d); check("R6", "any edge fall", d, 32'h200);
      quiesce();
   endtask

   task automatic t_level();
      logic [31:0] d;
      wr(6'h24, 32'h0000_0300);          // pin2 level high
      wr(6'h00, 32'h0000_0004);
      @(negedge clk); pin_i[2] = 1'b1; settle();
      wr(6'h0C, 32'h4);
      rd(6'h04, d); check("R7", "level high survives ack", d, 32'h004);
      @(negedge clk); pin_i[2] = 1'b0; settle();
      wr(6'h0C, 32'h4);
      rd(6'h04, d); check("R10", "level high gone then ack", d, 0);
      quiesce();
      wr(6'h28, 32'h0000_0200);          // pin10 level low, pin is low
      wr(6'h00, 32'h0000_0400);
      wr(6'h0C, 32'h400);
      rd(6'h04, d); check("R7", "level low survives ack", d, 32'h400);
      @(negedge clk); pin_i[10] = 1'b1; settle();
      wr(6'h0C, 32'h400);
      rd(6'h04, d); check("R7", "level low released", d, 0);
      @(negedge clk); pin_i[10] = 1'b0;
      quiesce();
   endtask

   task automatic t_enable_mask();
      logic [31:0] d;
      wr(6'h24, 32'h0000_1000);          // pin3 rising, disabled
      @(negedge clk); pin_i[3] = 1'b1; settle();
      rd(6'h04, d); check("R8", "disabled pin stays idle", d, 0);
      @(negedge clk); pin_i[3] = 1'b0; settle();
      wr(6'h00, 32'h8);
      wr(6'h10, 32'h8);                  // mask pin3 before the event
      @(negedge clk); pin_i[3] = 1'b1; settle();
      rd(6'h04, d); check("R9", "masked pin still latches", d, 32'h008);
      rd(6'h08, d); check("R9", "display hides masked", d, 0);
      check("R9", "irq masked", {31'h0, irq_o}, 0);
      wr(6'h10, 32'h0);
      wr(6'h14, 32'h0);
      rd(6'h10, d); check("R9", "zero writes keep mask", d, 32'h008);
      wr(6'h14, 32'h8);
      rd(6'h10, d); check("R9", "mask clear port", d, 0);
      rd(6'h08, d); check("R9", "display shows unmasked", d, 32'h008);
      check("R9", "irq unmasked", {31'h0, irq_o}, 1);
      @(negedge clk); pin_i[3] = 1'b0;
      quiesce();
   endtask

   task automatic t_mode_fields();
      logic [31:0] d;
      wr(6'h24, 32'hFFFF_FFFF);
      rd(6'h24, d); check("R11", "mode lo nibbles", d, 32'h7777_7777);
      wr(6'h28, 32'hFFFF_FFFF);
      rd(6'h28, d); check("R11", "mode hi nibbles", d, 32'h0000_7777);
      wr(6'h24, 32'h0000_0005);          // pin0 reserved code
      wr(6'h00, 32'h1);
      @(negedge clk); pin_i[0] = 1'b1; settle();
      rd(6'h04, d); check("R11", "reserved code idle", d, 0);
      @(negedge clk); pin_i[0] = 1'b0;
      quiesce();
   endtask

   task automatic t_sel_soft();
      logic [31:0] d;
      wr(6'h38, 32'hFFFF_FFFF);
      rd(6'h38, d); check("R13", "selection readback", d, ALL);
      check("R13", "use_sel_o", {20'h0, use_sel_o}, ALL);
      wr(6'h28, 32'h0000_0003);          // pin8 level high
      wr(6'h00, ALL); wr(6'h20, ALL); wr(6'h18, 32'h55);
      @(negedge clk); pin_i[8] = 1'b1; settle();
      check("R12", "irq before soft reset", {31'h0, irq_o}, 1);
      wr(6'h3C, 32'h1);
      wr(6'h3C, 32'h0);
      @(negedge clk); pin_i[8] = 1'b0;
      rd(6'h00, d); check("R12", "enable", d, 0);
      rd(6'h04, d); check("R12", "pending", d, 0);
      rd(6'h28, d); check("R12", "mode hi", d, 0);
      rd(6'h38, d); check("R12", "selection", d, 0);
      check("R12", "pins and irq", {pin_o, pin_oe_o, use_sel_o, 3'b000, irq_o}, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_port();
      t_input();
      t_rise_fall();
      t_any_edge();
      t_level();
      t_enable_mask();
      t_mode_fields();
      t_sel_soft();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule